// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block sits beside one processor and presents at most one interrupt to it at a time. It keeps a current processor priority, one pending slot (a source number and its priority), and an inter-processor interrupt priority. Source controllers offer requests with a source number and a priority. The presenter takes a request only when that request beats both the current priority and whatever already sits in the slot. An older source that loses its place is handed back through a reject pulse, so that its owner can offer it again later. An inter-processor interrupt is not queued separately. It competes for the same slot under a fixed source number.

Software drives the block through four register operations: accept, current-priority write, inter-processor priority write and end-of-interrupt. Accept takes the pending interrupt and raises the current priority to it. End-of-interrupt restores a priority and forwards the finished source number back to the source side. Relaxing the priority asks the sources to resend whatever they still hold. All register operations act on the clock edge. Their pulse outputs appear in the cycle that follows.

Top module: `intr_presenter`

## Requirements
- R1: After reset the status word reads 0 (current priority 0, no source), the internal pending priority and the inter-processor priority are 0xFF, the interrupt output is low and no pulse is active.
- R2: The status word carries the current priority in bits 31:24 and the pending source number in bits 23:0, where 0 means empty. The interrupt output is high exactly when the source field is nonzero.
- R3: A request with priority P is dropped, leaving all state and pulses unchanged, when P is not below the current priority, or when a source is pending with priority at most P.
- R4: A request that is taken stores its source and priority and raises the output. If the slot held a source taken from a request, that source number is rejected. An inter-processor entry that is displaced is dropped without a reject.
- R5: Accept returns the status word shown during the accept cycle. On the edge it loads the current priority with the old pending priority, clears the source field, sets the pending priority to 0xFF and lowers the output.
- R6: A current-priority write that lowers the value clears the slot when it is occupied and the new value is at most the pending priority. It then lowers the output and rejects the old source if that source came from a request.
- R7: A current-priority write that raises the value emits a resend pulse and runs the inter-processor check. A write of an equal value changes nothing.
- R8: An inter-processor priority write stores the value and runs the inter-processor check when the value is below the current priority. The check does nothing when a source is pending with priority at most that value. Otherwise it rejects any request-owned pending source and loads source number IPI_SRC (default 2) with that priority, raising the output.
- R9: An end-of-interrupt write loads the current priority from bits 31:24 of the written word. It emits an EOI pulse carrying bits 23:0 and a resend pulse. It then runs the inter-processor check if the inter-processor priority is below the new current priority.
- R10: Reject, EOI and resend are one-cycle registered pulses in the cycle after the triggering edge. At most one reject is emitted per cycle, and its source number is nonzero.
- R11: Within one cycle, accept beats a current-priority write, which beats an inter-processor write, which beats end-of-interrupt. A request in the same cycle is judged against the state that the register operation leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request from a source controller |
| req_src | input | 24 | Source number of the request |
| req_prio | input | 8 | Priority of the request |
| accept_rd | input | 1 | Accept read strobe |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_data | input | 8 | Current-priority write value |
| mfrr_wr | input | 1 | Inter-processor priority write strobe |
| mfrr_data | input | 8 | Inter-processor priority write value |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | End-of-interrupt word: priority and source |
| status_word | output | 32 | Current priority and pending source |
| irq_out | output | 1 | Interrupt level to the processor |
| reject_valid | output | 1 | Reject pulse |
| reject_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI forward pulse |
| eoi_src | output | 24 | Source number being completed |
| resend_valid | output | 1 | Resend request pulse |

## Verification
Several properties are checked on every cycle. The output level must track a nonzero source field. An empty slot and a pending priority of 0xFF must always go together. Two rejects must never coincide, and no reject may carry source 0. The output must drop after a lone accept, and an EOI pulse must echo the written low bits. The priority comparisons need the bench's scenarios, because the assertions cannot show them: taking or dropping a request at the equal-priority boundaries, displacement that rejects a request-owned source but silently drops an inter-processor entry, and the outcome of register writes that coincide with requests. The bench sweeps current, pending and incoming priorities over a small value set. It also runs a long mixed sequence against its own model.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SRC_W-1:0]  src_t;

  typedef struct packed {
    prio_t cppr;
    src_t  xisr;
    prio_t pend;
    prio_t mfrr;
    logic  owned;
  } pres_state_t;

  localparam prio_t PRIO_IDLE = '1;
endpackage

// File: rtl/ipres_reg_ops.sv
module ipres_reg_ops
  import ipres_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  pres_state_t           cur,
  input  logic                  accept_rd,
  input  logic                  cppr_wr,
  input  prio_t                 cppr_data,
  input  logic                  mfrr_wr,
  input  prio_t                 mfrr_data,
  input  logic                  eoi_wr,
  input  logic [WORD_W-1:0]     eoi_data,
  output pres_state_t           nxt,
  output logic                  rej_v,
  output src_t                  rej_src,
  output logic                  ipi_load,
  output logic                  clr_pend,
  output logic                  eoi_v,
  output src_t                  eoi_src,
  output logic                  resend_v
);
  localparam src_t IPI_CODE = src_t'(IPI_SRC);

  pres_state_t mid;
  logic        ipi_chk;
  prio_t       eoi_prio;

  assign eoi_prio = eoi_data[WORD_W-1:SRC_W];

  always_comb begin
    mid      = cur;
    nxt      = cur;
    rej_v    = 1'b0;
    rej_src  = '0;
    ipi_load = 1'b0;
    clr_pend = 1'b0;
    eoi_v    = 1'b0;
    eoi_src  = '0;
    resend_v = 1'b0;
    ipi_chk  = 1'b0;
    if (accept_rd) begin
      mid.cppr  = cur.pend;
      mid.xisr  = '0;
      mid.pend  = PRIO_IDLE;
      mid.owned = 1'b0;
      clr_pend  = 1'b1;
    end else if (cppr_wr) begin
      mid.cppr = cppr_data;
      if (cppr_data < cur.cppr) begin
        if ((cur.xisr != '0) && (cppr_data <= cur.pend)) begin
          rej_v     = cur.owned;
          rej_src   = cur.owned ? cur.xisr : '0;
          mid.xisr  = '0;
          mid.pend  = PRIO_IDLE;
          mid.owned = 1'b0;
          clr_pend  = 1'b1;
        end
      end else if (cppr_data > cur.cppr) begin
        resend_v = 1'b1;
        ipi_chk  = (cur.mfrr < cppr_data);
      end
    end else if (mfrr_wr) begin
      mid.mfrr = mfrr_data;
      ipi_chk  = (mfrr_data < cur.cppr);
    end else if (eoi_wr) begin
      mid.cppr = eoi_prio;
      eoi_v    = 1'b1;
      eoi_src  = eoi_data[SRC_W-1:0];
      resend_v = 1'b1;
      ipi_chk  = (cur.mfrr < eoi_prio);
    end
    nxt = mid;
    if (ipi_chk && !((mid.xisr != '0) && (mid.pend <= mid.mfrr))) begin
      if ((mid.xisr != '0) && mid.owned) begin
        rej_v   = 1'b1;
        rej_src = mid.xisr;
      end
      nxt.xisr  = IPI_CODE;
      nxt.pend  = mid.mfrr;
      nxt.owned = 1'b0;
      ipi_load  = 1'b1;
    end
  end
endmodule

// File: rtl/ipres_req_arb.sv
module ipres_req_arb
  import ipres_pkg::*;
(
  input  pres_state_t cur,
  input  logic        req_valid,
  input  src_t        req_src,
  input  prio_t       req_prio,
  output pres_state_t nxt,
  output logic        take,
  output logic        rej_v,
  output src_t        rej_src
);
  logic beats_cppr;
  logic beats_slot;

  assign beats_cppr = (req_prio < cur.cppr);
  assign beats_slot = (cur.xisr == '0) || (req_prio < cur.pend);
  assign take       = req_valid && beats_cppr && beats_slot;

  always_comb begin
    nxt     = cur;
    rej_v   = 1'b0;
    rej_src = '0;
    if (take) begin
      if ((cur.xisr != '0) && cur.owned) begin
        rej_v   = 1'b1;
        rej_src = cur.xisr;
      end
      nxt.xisr  = req_src;
      nxt.pend  = req_prio;
      nxt.owned = 1'b1;
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import ipres_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [23:0]       req_src,
  input  logic [7:0]        req_prio,
  input  logic              accept_rd,
  input  logic              cppr_wr,
  input  logic [7:0]        cppr_data,
  input  logic              mfrr_wr,
  input  logic [7:0]        mfrr_data,
  input  logic              eoi_wr,
  input  logic [31:0]       eoi_data,
  output logic [31:0]       status_word,
  output logic              irq_out,
  output logic              reject_valid,
  output logic [23:0]       reject_src,
  output logic              eoi_valid,
  output logic [23:0]       eoi_src,
  output logic              resend_valid
);
  pres_state_t state_q, state_d, s1, s2;
  logic rej1_v, rej2_v, ipi_load, clr_pend, take, eoi1_v, resend1_v;
  src_t rej1_src, rej2_src, eoi1_src;
  logic irq_q, irq_d;
  logic rej_q, eoi_q, res_q;
  src_t rej_src_q, eoi_src_q;
  logic rej_d;
  src_t rej_src_d;

  ipres_reg_ops #(.IPI_SRC(IPI_SRC)) u_ops (
    .cur(state_q), .accept_rd(accept_rd),
    .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .mfrr_wr(mfrr_wr), .mfrr_data(mfrr_data),
    .eoi_wr(eoi_wr), .eoi_data(eoi_data),
    .nxt(s1), .rej_v(rej1_v), .rej_src(rej1_src),
    .ipi_load(ipi_load), .clr_pend(clr_pend),
    .eoi_v(eoi1_v), .eoi_src(eoi1_src), .resend_v(resend1_v)
  );

  ipres_req_arb u_arb (
    .cur(s1), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .nxt(s2), .take(take), .rej_v(rej2_v), .rej_src(rej2_src)
  );

  always_comb begin
    state_d   = s2;
    rej_d     = rej1_v | rej2_v;
    rej_src_d = rej1_v ? rej1_src : (rej2_v ? rej2_src : '0);
    if (take || ipi_load)  irq_d = 1'b1;
    else if (clr_pend)     irq_d = 1'b0;
    else                   irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q.cppr  <= '0;
      state_q.xisr  <= '0;
      state_q.pend  <= PRIO_IDLE;
      state_q.mfrr  <= PRIO_IDLE;
      state_q.owned <= 1'b0;
      irq_q         <= 1'b0;
      rej_q         <= 1'b0;
      rej_src_q     <= '0;
      eoi_q         <= 1'b0;
      eoi_src_q     <= '0;
      res_q         <= 1'b0;
    end else begin
      state_q   <= state_d;
      irq_q     <= irq_d;
      rej_q     <= rej_d;
      rej_src_q <= rej_src_d;
      eoi_q     <= eoi1_v;
      eoi_src_q <= eoi1_src;
      res_q     <= resend1_v;
    end
  end

  assign status_word  = {state_q.cppr, state_q.xisr};
  assign irq_out      = irq_q;
  assign reject_valid = rej_q;
  assign reject_src   = rej_src_q;
  assign eoi_valid    = eoi_q;
  assign eoi_src      = eoi_src_q;
  assign resend_valid = res_q;

  // R2: output level follows the source field
  a_r2_irq_tracks_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (state_q.xisr != '0));
  // R2: empty slot and idle pending priority coincide
  a_r2_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.xisr == '0) == (state_q.pend == PRIO_IDLE));
  // R10: register stage and request stage never reject together
  a_r10_one_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(rej1_v && rej2_v));
  // R10: a reject always names a real source
  a_r10_reject_named: assert property (@(posedge clk) disable iff (!rst_n)
    reject_valid |-> (reject_src != '0));
  // R5: a lone accept drops the output
  a_r5_accept_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_rd && !req_valid) |=> !irq_out);
  // R9: end-of-interrupt forwards the low field
  a_r9_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !accept_rd && !cppr_wr && !mfrr_wr) |=>
      (eoi_valid && eoi_src == $past(eoi_data[SRC_W-1:0])));
endmodule

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid; logic [23:0] req_src; logic [7:0] req_prio;
  logic accept_rd, cppr_wr, mfrr_wr, eoi_wr;
  logic [7:0] cppr_data, mfrr_data; logic [31:0] eoi_data;
  logic [31:0] status_word; logic irq_out;
  logic reject_valid; logic [23:0] reject_src;
  logic eoi_valid; logic [23:0] eoi_src; logic resend_valid;

  int tests = 0;
  int fails = 0;

  // bench model state
  logic [7:0] mc, mp, mm; logic [23:0] mx; logic mo;
  logic e_rej; logic [23:0] e_rsrc; logic e_eoi; logic [23:0] e_esrc; logic e_res;

  localparam logic [23:0] IPI = 24'd2;
  localparam logic [7:0] POOL [6] = '{8'd0, 8'd1, 8'd3, 8'd5, 8'd7, 8'hFF};

  always #5 clk = ~clk;

  intr_presenter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .accept_rd(accept_rd), .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .mfrr_wr(mfrr_wr), .mfrr_data(mfrr_data), .eoi_wr(eoi_wr), .eoi_data(eoi_data),
    .status_word(status_word), .irq_out(irq_out), .reject_valid(reject_valid),
    .reject_src(reject_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_valid(resend_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_src = '0; req_prio = '0; accept_rd = 0;
    cppr_wr = 0; cppr_data = '0; mfrr_wr = 0; mfrr_data = '0; eoi_wr = 0; eoi_data = '0;
  endtask

  task automatic model_reset();
    mc = 8'd0; mx = '0; mp = 8'hFF; mm = 8'hFF; mo = 0;
  endtask

  task automatic model_step();
    logic chk_ipi;
    e_rej = 0; e_rsrc = '0; e_eoi = 0; e_esrc = '0; e_res = 0; chk_ipi = 0;
    if (accept_rd) begin
      mc = mp; mx = '0; mp = 8'hFF; mo = 0;
    end else if (cppr_wr) begin
      if (cppr_data < mc) begin
        if (mx != 0 && cppr_data <= mp) begin
          if (mo) begin e_rej = 1; e_rsrc = mx; end
          mx = '0; mp = 8'hFF; mo = 0;
        end
      end else if (cppr_data > mc) begin
        e_res = 1; chk_ipi = (mm < cppr_data);
      end
      mc = cppr_data;
    end else if (mfrr_wr) begin
      mm = mfrr_data; chk_ipi = (mfrr_data < mc);
    end else if (eoi_wr) begin
      mc = eoi_data[31:24]; e_eoi = 1; e_esrc = eoi_data[23:0]; e_res = 1;
      chk_ipi = (mm < mc);
    end
    if (chk_ipi && !(mx != 0 && mp <= mm)) begin
      if (mx != 0 && mo) begin e_rej = 1; e_rsrc = mx; end
      mx = IPI; mp = mm; mo = 0;
    end
    if (req_valid && req_prio < mc && !(mx != 0 && mp <= req_prio)) begin
      if (mx != 0 && mo) begin e_rej = 1; e_rsrc = mx; end
      mx = req_src; mp = req_prio; mo = 1;
    end
  endtask

  // inputs set at a falling edge; results sampled 1 ns after the next rising edge
  task automatic step(string tag);
    @(posedge clk);
    #1;
    model_step();
    chk({tag, " status"}, status_word, {mc, mx});
    chk({tag, " irq"}, {31'd0, irq_out}, {31'd0, (mx != 0)});
    chk({tag, " reject"}, {7'd0, reject_valid, reject_src}, {7'd0, e_rej, e_rsrc});
    chk({tag, " eoi"}, {7'd0, eoi_valid, eoi_src}, {7'd0, e_eoi, e_esrc});
    chk({tag, " resend"}, {31'd0, resend_valid}, {31'd0, e_res});
    idle_inputs();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic req(logic [23:0] s, logic [7:0] p, string tag);
    req_valid = 1; req_src = s; req_prio = p; step(tag);
  endtask
  task automatic wcppr(logic [7:0] v, string tag);
    cppr_wr = 1; cppr_data = v; step(tag);
  endtask
  task automatic wmfrr(logic [7:0] v, string tag);
    mfrr_wr = 1; mfrr_data = v; step(tag);
  endtask
  task automatic weoi(logic [31:0] v, string tag);
    eoi_wr = 1; eoi_data = v; step(tag);
  endtask
  task automatic acc(string tag);
    chk({tag, " accept word"}, status_word, {mc, mx});
    accept_rd = 1; step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    idle_inputs();
    do_reset();
    // R1 reset state
    chk("R1 status", status_word, 32'd0);
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    chk("R1 pulses", {29'd0, reject_valid, eoi_valid, resend_valid}, 32'd0);
    // R3 with current priority 0 everything is dropped
    req(24'h11, 8'd0, "R3 cppr0");
    // R7 raise to 0xFF gives resend; mfrr is 0xFF so no IPI
    wcppr(8'hFF, "R7 raise");
    wcppr(8'hFF, "R7 equal");
    // R4 take then displace
    req(24'h11, 8'd5, "R4 take");
    req(24'h12, 8'd5, "R3 equal pending");
    req(24'h13, 8'd3, "R4 displace");
    // R5 accept
    acc("R5 accept");
    // R9 eoi restores priority
    weoi({8'hFF, 24'h13}, "R9 eoi");
    // R8 IPI load and displacement
    req(24'h21, 8'd6, "R4 take2");
    wmfrr(8'd4, "R8 ipi displaces");
    wmfrr(8'd4, "R8 ipi kept");
    req(24'h22, 8'd1, "R4 ipi dropped silently");
    wmfrr(8'd0, "R8 ipi beats source");
    // R6 lowering cppr clears IPI silently then a request-owned source with reject
    wcppr(8'd0, "R6 clear ipi");
    wmfrr(8'hFF, "R8 mfrr idle");
    wcppr(8'hFF, "R7 raise2");
    req(24'h31, 8'd4, "R4 take3");
    wcppr(8'd5, "R6 keep better");
    wcppr(8'd4, "R6 clear equal");
    // R11 coincident operations
    wcppr(8'hFF, "R7 raise3");
    req_valid = 1; req_src = 24'h41; req_prio = 8'd2; accept_rd = 1; cppr_wr = 1; cppr_data = 8'd9;
    step("R11 accept wins with req");
    cppr_wr = 1; cppr_data = 8'h40; mfrr_wr = 1; mfrr_data = 8'd1; req_valid = 1; req_src = 24'h42;
    req_prio = 8'd3; step("R11 cppr wins with req");
    // R3 exhaustive sweep: current priority, pending priority, incoming priority
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++) begin
          do_reset();
          wcppr(POOL[a], "R7 sweep");
          req(24'h10, POOL[b], "R4 sweep");
          req(24'h20, POOL[c], "R3 sweep");
        end
    // R11 long mixed sequence against the model
    do_reset();
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      req_valid = lfsr[31]; req_src = {21'd0, lfsr[30:28]} + 24'd1;
      req_prio = POOL[lfsr[27:25] % 6];
      case (lfsr[24:22])
        3'd0: accept_rd = 1;
        3'd1: begin cppr_wr = 1; cppr_data = POOL[lfsr[21:19] % 6]; end
        3'd2: begin mfrr_wr = 1; mfrr_data = POOL[lfsr[21:19] % 6]; end
        3'd3: begin eoi_wr = 1; eoi_data = {POOL[lfsr[21:19] % 6], 21'd0, lfsr[18:16]}; end
        3'd4: begin accept_rd = lfsr[15]; cppr_wr = 1; cppr_data = POOL[lfsr[21:19] % 6];
                    mfrr_wr = lfsr[14]; mfrr_data = POOL[lfsr[13:11] % 6]; end
        default: ;
      endcase
      step("R11 mixed");
    end
    // R10 pulses last one cycle
    step("R10 quiet");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule